// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers up to sixteen single-bit event lines from a security subsystem into a sticky status word. It drives one level-sensitive interrupt request toward the system interrupt controller. Software reads the status word, acknowledges events by writing ones to it, and controls which events may raise the request through a mask.

Software cannot write the mask directly. It clears mask bits by writing ones to an enable register and sets mask bits by writing ones to a disable register. Because of this, two agents can each adjust their own bits without a read-modify-write race. After reset every defined source is masked.

The register port is a plain 32-bit word bus. It has an address, a write strobe and write data, and read data comes back combinationally from the current address. Source bit 0 flags cipher completion, bit 1 public-key completion, bit 2 hash completion and bit 13 tamper. Bit 12 is not connected.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x0000_0000, the mask reads 0x0000_EFFF (every defined source masked) and the interrupt output is 0.
- R2: A source bit high at a clock edge sets its status bit (offset 0x20) at that edge, whether or not it is masked, and the bit stays set until cleared.
- R3: A write to the status register (offset 0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When a source event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register (offset 0x24) is read-only; bus writes to it leave it unchanged.
- R6: A write to the enable register (offset 0x28) clears every mask bit written as 1 and leaves the others unchanged.
- R7: A write to the disable register (offset 0x2C) sets every defined mask bit written as 1 and leaves the others unchanged.
- R8: The enable and disable registers read as zero, and so does any address other than 0x20 and 0x24.
- R9: The interrupt output is a register. In each cycle it equals the OR over all bits of (status AND NOT mask) as held one cycle earlier.
- R10: Bit 12 and bits 16 to 31 of status and mask always read as zero, and an event on source bit 12 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | NUM_SRC (16) | Event lines, one per source, sampled each edge |
| bus_addr | input | ADDR_W (8) | Byte address of the word access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the current address |
| irq_out | output | 1 | Level interrupt request |

## Verification
A corrupted status or mask bit shows up in the combinational read data at once. On the next edge it shows up on the interrupt line, which is a single register stage behind the state. A bench reference model that tracks status and mask is therefore compared with the read data on every idle bus cycle and with the interrupt line on every cycle. A fault in the set-versus-clear priority, in the enable/disable polarity, or in the one-cycle output latency is caught within one or two clocks of the stimulus that exposes it.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

    localparam int unsigned SIC_OFS_STATUS  = 32'h20;
    localparam int unsigned SIC_OFS_MASK    = 32'h24;
    localparam int unsigned SIC_OFS_ENABLE  = 32'h28;
    localparam int unsigned SIC_OFS_DISABLE = 32'h2C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_ENABLE,
        SEL_DISABLE
    } sic_sel_e;

    // Per-cycle write actions produced by the address decode
    typedef struct packed {
        logic clr;
        logic unmask;
        logic mask;
    } sic_wr_t;

    function automatic sic_wr_t sic_wr_action(input logic we, input sic_sel_e sel);
        sic_wr_t a;
        a.clr    = we && (sel == SEL_STATUS);
        a.unmask = we && (sel == SEL_ENABLE);
        a.mask   = we && (sel == SEL_DISABLE);
        return a;
    endfunction

endpackage

// File: rtl/sic_status.sv
module sic_status #(
    parameter int unsigned      NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0] SRC_USED = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] status
);
    // Set dominates clear so a coincident event survives acknowledgement
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (SRC_USED[i]) begin : g_used
            always_ff @(posedge clk) begin
                if (rst) begin
                    status[i] <= 1'b0;
                end else if (src_evt[i]) begin
                    status[i] <= 1'b1;
                end else if (clr_en && clr_bits[i]) begin
                    status[i] <= 1'b0;
                end
            end
        end else begin : g_tied
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sic_mask.sv
module sic_mask #(
    parameter int unsigned      NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0] SRC_USED = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               unmask_en,
    input  logic               mask_en,
    input  logic [NUM_SRC-1:0] bits,
    output logic [NUM_SRC-1:0] mask
);
    logic [NUM_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= SRC_USED;
        end else if (unmask_en) begin
            mask_q <= mask_q & ~bits;
        end else if (mask_en) begin
            mask_q <= mask_q | (bits & SRC_USED);
        end
    end

    assign mask = mask_q & SRC_USED;
endmodule

// File: rtl/sic_irq_out.sv
module sic_irq_out #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(status & ~mask);
        end
    end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sec_irq_pkg::*;
#(
    parameter int unsigned        NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0] SRC_USED = 16'hEFFF,
    parameter int unsigned        ADDR_W   = 8,
    parameter int unsigned        DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(SIC_OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(SIC_OFS_MASK);
    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(SIC_OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(SIC_OFS_DISABLE);
    localparam int unsigned       PAD_W     = DATA_W - NUM_SRC;

    sic_sel_e           sel;
    sic_wr_t            act;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;

    always_comb begin
        case (bus_addr)
            A_STATUS:  sel = SEL_STATUS;
            A_MASK:    sel = SEL_MASK;
            A_ENABLE:  sel = SEL_ENABLE;
            A_DISABLE: sel = SEL_DISABLE;
            default:   sel = SEL_NONE;
        endcase
    end

    assign act   = sic_wr_action(bus_we, sel);
    assign wbits = bus_wdata[NUM_SRC-1:0];

    sic_status #(.NUM_SRC(NUM_SRC), .SRC_USED(SRC_USED)) u_status (
        .clk      (clk),
        .rst      (rst),
        .src_evt  (src_evt),
        .clr_en   (act.clr),
        .clr_bits (wbits),
        .status   (status_q)
    );

    sic_mask #(.NUM_SRC(NUM_SRC), .SRC_USED(SRC_USED)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .unmask_en (act.unmask),
        .mask_en   (act.mask),
        .bits      (wbits),
        .mask      (mask_q)
    );

    sic_irq_out #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .status (status_q),
        .mask   (mask_q),
        .irq    (irq_out)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, status_q};
            SEL_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk
    import sec_irq_pkg::*;
#(
    parameter int unsigned        NUM_SRC  = 16,
    parameter logic [NUM_SRC-1:0] SRC_USED = 16'hEFFF,
    parameter int unsigned        ADDR_W   = 8,
    parameter int unsigned        DATA_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               irq_out
);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(SIC_OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(SIC_OFS_MASK);
    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(SIC_OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(SIC_OFS_DISABLE);

    // R1
    reset_mask_chk: assert property (@(posedge clk)
        rst |=> (mask_q == SRC_USED) && (status_q == '0) && !irq_out);

    // R2
    latch_chk: assert property (@(posedge clk) disable iff (rst)
        ((src_evt & SRC_USED) != '0) |=>
            ((status_q & $past(src_evt & SRC_USED)) == $past(src_evt & SRC_USED)));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_STATUS && ((src_evt & SRC_USED) != '0)) |=>
            ((status_q & $past(src_evt & SRC_USED)) == $past(src_evt & SRC_USED)));

    // R5
    mask_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_MASK) |=> $stable(mask_q));

    // R6
    enable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENABLE) |=>
            ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R7
    disable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DISABLE) |=>
            ((mask_q & $past(bus_wdata[NUM_SRC-1:0] & SRC_USED)) ==
             $past(bus_wdata[NUM_SRC-1:0] & SRC_USED)));

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(status_q & ~mask_q))));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q | mask_q) & ~SRC_USED) == '0);
endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .SRC_USED(SRC_USED), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_evt   (src_evt),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq_out   (irq_out)
);

// File: tb/tb_sec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sec_irq_ctrl;
    localparam logic [15:0] USED = 16'hEFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_evt = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_status;
    logic [15:0] m_mask;
    logic        m_irq;

    always #2.5 clk = ~clk;

    sec_irq_ctrl dut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h20:   return {16'h0, m_status};
            8'h24:   return {16'h0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check read and irq, advance model over the edge
    task automatic cyc(input logic [15:0] src, input logic we,
                       input logic [7:0] a, input logic [31:0] wd, input string tag);
        logic [15:0] ns;
        logic [15:0] nm;
        src_evt = src; bus_we = we; bus_addr = a; bus_wdata = wd;
        #1;
        check(irq_out == m_irq, {tag, " R9 irq"}, {31'h0, irq_out}, {31'h0, m_irq});
        if (!we) check(bus_rdata == exp_read(a), {tag, " read"}, bus_rdata, exp_read(a));
        ns = m_status;
        nm = m_mask;
        if (we && a == 8'h20) ns = ns & ~wd[15:0];
        ns = ns | (src & USED);
        if (we && a == 8'h28) nm = nm & ~wd[15:0];
        if (we && a == 8'h2C) nm = nm | (wd[15:0] & USED);
        @(posedge clk);
        m_irq = |(m_status & ~m_mask);
        m_status = ns;
        m_mask = nm;
        @(negedge clk);
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_status = '0; m_mask = USED; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values, R8 enable/disable/other read zero
        cyc(16'h0, 1'b0, 8'h20, 0, "R1 status");
        cyc(16'h0, 1'b0, 8'h24, 0, "R1 mask");
        cyc(16'h0, 1'b0, 8'h28, 0, "R8 enable");
        cyc(16'h0, 1'b0, 8'h2C, 0, "R8 disable");
        cyc(16'h0, 1'b0, 8'h30, 0, "R8 other");
        // R2 masked event still latches, irq stays low
        cyc(16'h0001, 1'b0, 8'h20, 0, "R2 pulse");
        cyc(16'h0, 1'b0, 8'h20, 0, "R2 sticky");
        cyc(16'h0, 1'b0, 8'h20, 0, "R2 masked irq");
        // R6 enable bit 0, R9 irq rises one cycle later
        cyc(16'h0, 1'b1, 8'h28, 32'h1, "R6 enable");
        cyc(16'h0, 1'b0, 8'h24, 0, "R6 mask");
        cyc(16'h0, 1'b0, 8'h24, 0, "R9 rise");
        // R5 mask write ignored
        cyc(16'h0, 1'b1, 8'h24, 32'hFFFF_FFFF, "R5 write");
        cyc(16'h0, 1'b0, 8'h24, 0, "R5 mask");
        // R3 write-one-to-clear, zero bits untouched
        cyc(16'h2004, 1'b0, 8'h20, 0, "R3 setup");
        cyc(16'h0, 1'b1, 8'h20, 32'h0000_0001, "R3 clear");
        cyc(16'h0, 1'b0, 8'h20, 0, "R3 status");
        cyc(16'h0, 1'b0, 8'h20, 0, "R9 fall");
        // R4 set wins over clear
        cyc(16'h0004, 1'b1, 8'h20, 32'h0000_0004, "R4 race");
        cyc(16'h0, 1'b0, 8'h20, 0, "R4 status");
        // R7 disable sets mask bits
        cyc(16'h0, 1'b1, 8'h2C, 32'h0000_0001, "R7 disable");
        cyc(16'h0, 1'b0, 8'h24, 0, "R7 mask");
        // R10 bit 12 and high bits read zero
        cyc(16'h1000, 1'b1, 8'h28, 32'hFFFF_FFFF, "R10 unmask all");
        cyc(16'h0, 1'b1, 8'h2C, 32'hFFFF_1000, "R10 disable hi");
        cyc(16'h0, 1'b0, 8'h20, 0, "R10 status");
        cyc(16'h0, 1'b0, 8'h24, 0, "R10 mask");
        // Random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] s;
            logic [7:0]  a;
            logic [2:0]  pick;
            s = ($urandom % 4 == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            pick = 3'($urandom % 5);
            case (pick)
                3'd0: a = 8'h20;
                3'd1: a = 8'h24;
                3'd2: a = 8'h28;
                3'd3: a = 8'h2C;
                default: a = 8'h34;
            endcase
            cyc(s, ($urandom % 3 == 0), a, $urandom, "R2-rand");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule